// File: doc/BRIEF.md
# Engine Stop and Register Access Controller

This block manages the shutdown of a coprocessor engine and controls bus access to that engine's registers. Software sets a module-disable bit in a global control register. If the microengine is running a thread at that moment, the engine does not stop until the thread finishes. The finishing thread may still raise interrupt or DMA requests, and those requests are kept. The stopped status flag is set only when the engine has actually stopped.

The block splits the register bus into two spaces. Channel space gives per-channel access to the request flags. Global space holds the control register and two write-one-to-clear flag vectors, each with one bit per channel. While the engine is stopped, every channel-space access ends with a bus error. Global space keeps working, so software can still see and clear pending requests. The DMA controller's acknowledge also keeps clearing DMA request flags while the engine is stopped.

Top module: `eng_stop_ctrl`

## Requirements
- R1: After reset, the stopped flag, the module-disable bit, all interrupt flags and all DMA flags are 0, and the control register reads as 0.
- R2: If no thread is running, a write of 1 to control bit 0 (global offset 0) sets the module-disable bit at the write edge. The stopped flag (control bit 1) then sets on the following clock edge.
- R3: While the thread-running input is high, the stopped flag does not rise. It sets on the first clock edge at which the disable bit is 1 and no thread is running.
- R4: Interrupt and DMA set pulses that arrive while disable is pending and a thread is still running are recorded in the flags.
- R5: While stopped, a read or write to channel space (address MSB = 1) gives bus_err_o = 1 and bus_ack_o = 0 in the cycle after the request, and changes no flag.
- R6: While stopped, global offset 1 (interrupt flags) and global offset 2 (DMA flags) read back the flag vectors, with bit n = channel n. Writing 1 to a bit clears that flag.
- R7: A pulse on dma_ack_i[n] clears DMA flag n at that clock edge, whether or not the engine is stopped.
- R8: Writing 0 to control bit 0 clears the disable bit. The stopped flag clears on the next edge, and channel-space accesses are acknowledged again.
- R9: A set pulse on the same edge as a write-one-to-clear or a DMA acknowledge leaves the flag at 1.
- R10: When the engine is not stopped, a channel-space read with the channel index in the low address bits returns that channel's interrupt flag in bit 0 and its DMA flag in bit 1, with bus_ack_o = 1 in the cycle after the request.
- R11: irq_o and dma_o drive the current flag vectors, with bit n = channel n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Bus access valid for one cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Register address; MSB selects channel space |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid with bus_ack_o |
| bus_ack_o | output | 1 | Access completed, one cycle after the request |
| bus_err_o | output | 1 | Access ended with a bus error |
| thread_run_i | input | 1 | Microengine is executing a thread |
| irq_set_i | input | NUM_CH | Interrupt request pulses, one per channel |
| dma_set_i | input | NUM_CH | DMA request pulses, one per channel |
| dma_ack_i | input | NUM_CH | DMA controller acknowledges, one per channel |
| stopped_o | output | 1 | Engine has stopped |
| irq_o | output | NUM_CH | Interrupt request flags |
| dma_o | output | NUM_CH | DMA request flags |

## Verification
Several properties are checked on every cycle:
- A running thread holds off the stop.
- An idle engine with disable set stops on the next edge.
- Clearing disable drops the stopped flag.
- Channel accesses while stopped answer with an error.
- Set pulses always land in the flags.
- A lone DMA acknowledge empties its flag.
- Ack and error are never both raised.

Only the directed scenarios show the following:
- The exact edge on which the stop happens after a long thread.
- That requests raised by the finishing thread survive.
- The read data of the global and channel registers.
- That erroring channel writes leave the flags untouched.
- That normal channel access returns after re-enable.

// File: rtl/eng_stop_pkg.sv
package eng_stop_pkg;
  typedef enum logic [1:0] {
    GREG_CTRL = 2'd0,
    GREG_IRQ  = 2'd1,
    GREG_DMA  = 2'd2,
    GREG_RSVD = 2'd3
  } greg_e;

  localparam int unsigned CTRL_MDIS_BIT = 0;
  localparam int unsigned CTRL_STOP_BIT = 1;
endpackage

// File: rtl/eng_stop_fsm.sv
module eng_stop_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mdis_i,
  input  logic thread_run_i,
  output logic stopped_o
);
  logic stopped_q;

  // stop only once the current thread has retired; leave as soon as disable drops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stopped_q <= 1'b0;
    else         stopped_q <= mdis_i & (stopped_q | ~thread_run_i);
  end

  assign stopped_o = stopped_q;
endmodule

// File: rtl/eng_flag_bank.sv
module eng_flag_bank #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] flag_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       f_q <= 1'b0;
      else if (set_i[g]) f_q <= 1'b1;  // set beats clear
      else if (clr_i[g]) f_q <= 1'b0;
    end
    assign flag_o[g] = f_q;
  end
endmodule

// File: rtl/eng_bus_decode.sv
module eng_bus_decode
  import eng_stop_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              stopped_i,
  output logic              chan_rd_o,
  output logic              glob_rd_o,
  output greg_e             greg_o,
  output logic [CH_W-1:0]   ch_idx_o,
  output logic              wr_ctrl_o,
  output logic              wr_irq_o,
  output logic              wr_dma_o,
  output logic              err_o
);
  logic chan_sel, glob_sel;

  assign chan_sel  = req_i &  addr_i[ADDR_W-1];
  assign glob_sel  = req_i & ~addr_i[ADDR_W-1];
  assign greg_o    = greg_e'(addr_i[1:0]);
  assign ch_idx_o  = addr_i[CH_W-1:0];

  assign err_o     = chan_sel & stopped_i;
  assign chan_rd_o = chan_sel & ~stopped_i & ~we_i;
  assign glob_rd_o = glob_sel & ~we_i;
  assign wr_ctrl_o = glob_sel & we_i & (greg_o == GREG_CTRL);
  assign wr_irq_o  = glob_sel & we_i & (greg_o == GREG_IRQ);
  assign wr_dma_o  = glob_sel & we_i & (greg_o == GREG_DMA);
endmodule

// File: rtl/eng_stop_ctrl.sv
module eng_stop_ctrl
  import eng_stop_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_ack_o,
  output logic              bus_err_o,
  input  logic              thread_run_i,
  input  logic [NUM_CH-1:0] irq_set_i,
  input  logic [NUM_CH-1:0] dma_set_i,
  input  logic [NUM_CH-1:0] dma_ack_i,
  output logic              stopped_o,
  output logic [NUM_CH-1:0] irq_o,
  output logic [NUM_CH-1:0] dma_o
);
  localparam int unsigned CH_W = $clog2(NUM_CH);

  logic              mdis_q;
  logic              chan_rd, glob_rd, wr_ctrl, wr_irq, wr_dma, err_n;
  greg_e             greg;
  logic [CH_W-1:0]   ch_idx;
  logic [NUM_CH-1:0] irq_clr, dma_clr;
  logic [DATA_W-1:0] rdata_n;

  eng_bus_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
    .req_i     (bus_req_i),
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .stopped_i (stopped_o),
    .chan_rd_o (chan_rd),
    .glob_rd_o (glob_rd),
    .greg_o    (greg),
    .ch_idx_o  (ch_idx),
    .wr_ctrl_o (wr_ctrl),
    .wr_irq_o  (wr_irq),
    .wr_dma_o  (wr_dma),
    .err_o     (err_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mdis_q <= 1'b0;
    else if (wr_ctrl) mdis_q <= bus_wdata_i[CTRL_MDIS_BIT];
  end

  eng_stop_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mdis_i       (mdis_q),
    .thread_run_i (thread_run_i),
    .stopped_o    (stopped_o)
  );

  assign irq_clr = wr_irq ? bus_wdata_i[NUM_CH-1:0] : '0;
  assign dma_clr = (wr_dma ? bus_wdata_i[NUM_CH-1:0] : '0) | dma_ack_i;

  eng_flag_bank #(.NUM_CH(NUM_CH)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (irq_set_i),
    .clr_i  (irq_clr),
    .flag_o (irq_o)
  );

  eng_flag_bank #(.NUM_CH(NUM_CH)) u_dma (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (dma_set_i),
    .clr_i  (dma_clr),
    .flag_o (dma_o)
  );

  always_comb begin
    rdata_n = '0;
    if (chan_rd) begin
      rdata_n[0] = irq_o[ch_idx];
      rdata_n[1] = dma_o[ch_idx];
    end else if (glob_rd) begin
      unique case (greg)
        GREG_CTRL: begin
          rdata_n[CTRL_MDIS_BIT] = mdis_q;
          rdata_n[CTRL_STOP_BIT] = stopped_o;
        end
        GREG_IRQ:  rdata_n[NUM_CH-1:0] = irq_o;
        GREG_DMA:  rdata_n[NUM_CH-1:0] = dma_o;
        default:   rdata_n = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_ack_o   <= 1'b0;
      bus_err_o   <= 1'b0;
      bus_rdata_o <= '0;
    end else begin
      bus_ack_o   <= bus_req_i & ~err_n;
      bus_err_o   <= err_n;
      bus_rdata_o <= rdata_n;
    end
  end
endmodule

// File: rtl/eng_stop_ctrl_chk.sv
module eng_stop_ctrl_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              thread_run_i,
  input logic [NUM_CH-1:0] irq_set_i,
  input logic [NUM_CH-1:0] dma_set_i,
  input logic [NUM_CH-1:0] dma_ack_i,
  input logic              mdis_q,
  input logic              stopped_o,
  input logic [NUM_CH-1:0] irq_o,
  input logic [NUM_CH-1:0] dma_o,
  input logic              bus_ack_o,
  input logic              bus_err_o
);
  assert_stop_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdis_q && !thread_run_i) |=> stopped_o);

  assert_thread_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stopped_o && thread_run_i) |=> !stopped_o);

  assert_chan_err_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stopped_o && bus_req_i && bus_addr_i[ADDR_W-1]) |=> (bus_err_o && !bus_ack_o));

  assert_resume_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mdis_q |=> !stopped_o);

  assert_resp_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bus_ack_o, bus_err_o}));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assert_irq_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_set_i[g] |=> irq_o[g]);
    assert_dma_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dma_set_i[g] |=> dma_o[g]);
    assert_dma_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dma_ack_i[g] && !dma_set_i[g]) |=> !dma_o[g]);
  end
endmodule

bind eng_stop_ctrl eng_stop_ctrl_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_eng_stop_ctrl.sv
module sim_eng_stop_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 8;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] A_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] A_IRQ  = 8'h01;
  localparam logic [ADDR_W-1:0] A_DMA  = 8'h02;
  localparam logic [ADDR_W-1:0] A_CHAN = 8'h80;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              ack, err, run = 1'b0, stopped;
  logic [NUM_CH-1:0] irq_set = '0, dma_set = '0, dma_ack = '0, irq, dma;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] r_data;
  logic r_ack, r_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  eng_stop_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .bus_ack_o(ack), .bus_err_o(err), .thread_run_i(run),
    .irq_set_i(irq_set), .dma_set_i(dma_set), .dma_ack_i(dma_ack),
    .stopped_o(stopped), .irq_o(irq), .dma_o(dma)
  );

  task automatic chk(input string req_tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  // drives one access; returns the response sampled just after the edge
  task automatic bus(input logic w, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(posedge clk); #1;
    r_ack = ack; r_err = err; r_data = rdata;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic pulse(input logic [NUM_CH-1:0] is, input logic [NUM_CH-1:0] ds, input logic [NUM_CH-1:0] da);
    @(negedge clk);
    irq_set = is; dma_set = ds; dma_ack = da;
    @(negedge clk);
    irq_set = '0; dma_set = '0; dma_ack = '0;
  endtask

  task automatic t_reset;
    chk("R1", {29'd0, stopped, |irq, |dma}, '0);
    bus(1'b0, A_CTRL, '0);
    chk("R1", {30'd0, r_ack, r_err}, 32'd2);
    chk("R1", r_data, '0);
  endtask

  task automatic t_chan_read;
    pulse(8'h08, 8'h20, 8'h00);
    chk("R11", {16'd0, irq, dma}, 32'h0820);
    bus(1'b0, A_CHAN | 8'd3, '0);
    chk("R10", {r_ack, r_err, r_data[29:0]}, {2'b10, 30'd1});
    bus(1'b0, A_CHAN | 8'd5, '0);
    chk("R10", {r_ack, r_err, r_data[29:0]}, {2'b10, 30'd2});
    bus(1'b1, A_IRQ, 32'h08);
    bus(1'b1, A_DMA, 32'h20);
    chk("R6", {16'd0, irq, dma}, '0);
  endtask

  task automatic t_stop_idle;
    bus(1'b1, A_CTRL, 32'h1);
    chk("R2", {31'd0, stopped}, 0);
    @(posedge clk); #1;
    chk("R2", {31'd0, stopped}, 1);
    bus(1'b0, A_CTRL, '0);
    chk("R2", r_data, 32'h3);
    bus(1'b1, A_CTRL, 32'h0);
    chk("R8", {31'd0, stopped}, 1);
    @(posedge clk); #1;
    chk("R8", {31'd0, stopped}, 0);
  endtask

  task automatic t_stop_busy;
    @(negedge clk) run = 1'b1;
    bus(1'b1, A_CTRL, 32'h1);
    pulse(8'h02, 8'h04, 8'h00);
    repeat (3) @(posedge clk);
    #1 chk("R3", {31'd0, stopped}, 0);
    chk("R4", {16'd0, irq, dma}, 32'h0204);
    @(negedge clk) run = 1'b0;
    @(posedge clk); #1;
    chk("R3", {31'd0, stopped}, 1);
    bus(1'b0, A_CHAN | 8'd1, '0);
    chk("R5", {30'd0, r_ack, r_err}, 32'd1);
    bus(1'b1, A_CHAN | 8'd1, 32'hFF);
    chk("R5", {30'd0, r_ack, r_err}, 32'd1);
    chk("R5", {16'd0, irq, dma}, 32'h0204);
    bus(1'b0, A_IRQ, '0);
    chk("R6", {r_ack, r_err, r_data[29:0]}, {2'b10, 30'h02});
    bus(1'b0, A_DMA, '0);
    chk("R6", r_data, 32'h04);
    bus(1'b1, A_IRQ, 32'h02);
    chk("R6", {24'd0, irq}, '0);
    pulse(8'h00, 8'h00, 8'h04);
    chk("R7", {24'd0, dma}, '0);
  endtask

  task automatic t_set_wins;
    pulse(8'h10, 8'h40, 8'h00);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = A_IRQ; wdata = 32'h10; irq_set = 8'h10; dma_ack = 8'h40; dma_set = 8'h40;
    @(negedge clk);
    req = 1'b0; we = 1'b0; irq_set = '0; dma_ack = '0; dma_set = '0;
    chk("R9", {16'd0, irq, dma}, 32'h1040);
    bus(1'b1, A_IRQ, 32'h10);
    bus(1'b1, A_DMA, 32'h40);
    chk("R9", {16'd0, irq, dma}, '0);
  endtask

  task automatic t_resume;
    bus(1'b1, A_CTRL, 32'h0);
    @(posedge clk); #1;
    chk("R8", {31'd0, stopped}, 0);
    pulse(8'h80, 8'h00, 8'h00);
    bus(1'b0, A_CHAN | 8'd7, '0);
    chk("R8", {r_ack, r_err, r_data[29:0]}, {2'b10, 30'd1});
    bus(1'b1, A_IRQ, 32'h80);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_chan_read();
    t_stop_idle();
    t_stop_busy();
    t_set_wins();
    t_resume();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule